// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the low-order bits of a memory word address during a burst. When a new access begins, the cycle controller pulses the load input. The block then captures the two-bit starting offset from the external address bus and presents it at once. Each later cycle with advance asserted moves the offset one beat along the burst. A cycle with advance released holds the offset, which suspends the burst. The upper address bits are held elsewhere and are joined to this output outside the block.

Two beat orders are supported, and a static order input selects between them. In linear order each beat adds one to the start offset, modulo four. In interleaved order the beat number is XORed into the start offset. Either way, a burst of four beats comes back to its start offset. A load may be issued on every cycle, so plain single accesses need no burst at all. All pins here are plain control and address lines. No data flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no load since, `addr_o` is 0.
- R2: A cycle with `ld_i`=1 makes `addr_o` equal to that cycle's `preset_i` from the following cycle on, in either order.
- R3: When `ld_i`=1 and `adv_n_i`=0 fall in the same cycle, the load wins. The next `addr_o` is `preset_i`, and the beat count restarts at zero.
- R4: With `order_i`=0 (linear), each advance cycle (`adv_n_i`=0, `ld_i`=0) adds 1 modulo 4 to `addr_o`. From 2 the sequence is 2,3,0,1.
- R5: With `order_i`=1 (interleaved), `addr_o` equals the start offset XOR the beat count. From 1 the sequence is 1,0,3,2; from 3 it is 3,2,1,0.
- R6: A cycle with `adv_n_i`=1 and `ld_i`=0 leaves `addr_o` unchanged.
- R7: After four advances without a load, `addr_o` is back at the loaded start offset, so the fifth beat repeats the first.
- R8: Loads on consecutive cycles each take effect, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_i | input | 1 | Capture `preset_i` as a new start offset and zero the beat count |
| adv_n_i | input | 1 | Advance one beat when low; hold when high |
| order_i | input | 1 | 0 selects linear order, 1 selects interleaved order |
| preset_i | input | 2 | Start offset taken from the external address bus |
| addr_o | output | 2 | Current low address offset |

## Verification
Either stored value can go wrong: the start offset or the beat count. A corrupted start offset shows on `addr_o` in the very next cycle after the load, and it stays wrong for the whole burst. A wrong beat count shows on the first advance. It hides only while the burst is suspended, and it appears with the next advance or when the order input changes. Because the two orders combine start and count differently, stimulus covers both orders across all four start offsets. This catches a design that mixes up addition and XOR, since the two agree for some start offsets.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] preset,
  output logic [W-1:0] start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  start_q <= '0;
    else if (ld) start_q <= preset;
  end

  // start offset captured on load
  assert_start_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> start_q == $past(preset));
  // start offset held between loads
  assert_start_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(start_q));
endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         adv_n,
  output logic [W-1:0] step_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      step_q <= '0;
    else if (ld)     step_q <= '0;
    else if (!adv_n) step_q <= step_q + 1'b1;
  end

  assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> step_q == '0);
  assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv_n) |=> $stable(step_q));
endmodule

// File: rtl/burst_addr_mix.sv
module burst_addr_mix
  import burst_addr_pkg::*;
#(
  parameter int W = 2
) (
  input  order_e       order,
  input  logic [W-1:0] start,
  input  logic [W-1:0] step,
  output logic [W-1:0] addr
);
  logic [W:0]   carry;
  logic [W-1:0] sum;

  assign carry[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_ripple
    assign sum[i]     = start[i] ^ step[i] ^ carry[i];
    assign carry[i+1] = (start[i] & step[i]) | (carry[i] & (start[i] ^ step[i]));
  end

  always_comb begin
    if (order == ORDER_INTERLEAVE) addr = start ^ step;
    else                           addr = sum;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic         adv_n_i,
  input  logic         order_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] addr_o
);
  localparam logic [W-1:0] LAST_STEP = {W{1'b1}};

  logic [W-1:0] start_q;
  logic [W-1:0] step_q;
  order_e       order;

  assign order = order_e'(order_i);

  burst_start_reg #(.W(W)) u_start (
    .clk(clk), .rst_n(rst_n), .ld(ld_i), .preset(preset_i), .start_q(start_q));

  burst_step_ctr #(.W(W)) u_step (
    .clk(clk), .rst_n(rst_n), .ld(ld_i), .adv_n(adv_n_i), .step_q(step_q));

  burst_addr_mix #(.W(W)) u_mix (
    .order(order), .start(start_q), .step(step_q), .addr(addr_o));

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> addr_o == '0 || !rst_n);
  assert_linear_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !adv_n_i && !order_i) |=> (order_i || addr_o == $past(addr_o) + 1'b1));
  assert_interleave_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !adv_n_i && order_i && !step_q[0]) |=>
      (!order_i || (addr_o ^ $past(addr_o)) == {{(W-1){1'b0}}, 1'b1}));
  assert_wrap_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !adv_n_i && step_q == LAST_STEP) |=> addr_o == start_q);
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_i, adv_n_i, order_i;
  logic [1:0] preset_i;
  logic [1:0] addr_o;

  int checks = 0;
  int fails  = 0;
  logic [1:0] m_start = 2'd0;
  logic [1:0] m_step  = 2'd0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .adv_n_i(adv_n_i),
    .order_i(order_i), .preset_i(preset_i), .addr_o(addr_o));

  function automatic logic [1:0] exp_addr(logic [1:0] s, logic [1:0] k, logic ord);
    return ord ? (s ^ k) : (s + k);
  endfunction

  task automatic check(string req, logic [1:0] exp);
    checks++;
    if (addr_o !== exp) begin
      fails++;
      $display("FAIL %s: addr_o=%0d expected=%0d", req, addr_o, exp);
    end
  endtask

  // drive at negedge, clock once, update model, check at next negedge
  task automatic cyc(logic ld, logic adv_n, logic ord, logic [1:0] pre, string req);
    ld_i = ld; adv_n_i = adv_n; order_i = ord; preset_i = pre;
    @(posedge clk);
    if (ld) begin m_start = pre; m_step = 2'd0; end
    else if (!adv_n) m_step = m_step + 2'd1;
    @(negedge clk);
    check(req, exp_addr(m_start, m_step, ord));
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: addr_o=%0d expected=finish", addr_o);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; ld_i = 0; adv_n_i = 1; order_i = 0; preset_i = 2'd3;
    repeat (3) @(negedge clk);
    check("R1", 2'd0);
    rst_n = 1;
    cyc(0, 1, 0, 2'd3, "R1");
    // linear from 2: 2,3,0,1 then wrap (R4, R7)
    cyc(1, 1, 0, 2'd2, "R2");
    cyc(0, 0, 0, 2'd0, "R4"); check("R4", 2'd3);
    cyc(0, 0, 0, 2'd0, "R4"); check("R4", 2'd0);
    cyc(0, 0, 0, 2'd0, "R4"); check("R4", 2'd1);
    cyc(0, 0, 0, 2'd0, "R7"); check("R7", 2'd2);
    // interleaved from 1: 1,0,3,2
    cyc(1, 1, 1, 2'd1, "R2"); check("R2", 2'd1);
    cyc(0, 0, 1, 2'd0, "R5"); check("R5", 2'd0);
    cyc(0, 1, 1, 2'd0, "R6"); check("R6", 2'd0);
    cyc(0, 0, 1, 2'd0, "R5"); check("R5", 2'd3);
    cyc(0, 0, 1, 2'd0, "R5"); check("R5", 2'd2);
    cyc(0, 0, 1, 2'd0, "R7"); check("R7", 2'd1);
    // interleaved from 3: 3,2,1,0
    cyc(1, 0, 1, 2'd3, "R3"); check("R3", 2'd3);
    cyc(0, 0, 1, 2'd0, "R5"); check("R5", 2'd2);
    cyc(0, 0, 1, 2'd0, "R5"); check("R5", 2'd1);
    // load priority mid-burst restarts beats
    cyc(1, 0, 0, 2'd1, "R3"); check("R3", 2'd1);
    cyc(0, 0, 0, 2'd0, "R3"); check("R3", 2'd2);
    // back-to-back loads
    cyc(1, 1, 0, 2'd0, "R8"); check("R8", 2'd0);
    cyc(1, 1, 0, 2'd3, "R8"); check("R8", 2'd3);
    cyc(1, 1, 1, 2'd2, "R8"); check("R8", 2'd2);
    // suspend holds in linear
    cyc(0, 1, 0, 2'd1, "R6"); check("R6", 2'd2);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic l, a, o;
      l = ($urandom % 5) == 0;
      a = ($urandom % 3) == 0;
      o = (i / 50) % 2 == 1;
      cyc(l, a, o, 2'($urandom), o ? "R5" : "R4");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule